// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block watches 32 external interrupt pins and turns the activity on each one into a latched interrupt request. Each pin is first brought into the clock domain through a two-stage synchroniser. Software then picks one of five trigger conditions for the pin: low level, high level, falling edge, rising edge or either edge. When the condition is met, a pending bit for that pin is set. The bit stays set until software clears it, or is set again while a level condition persists. A per-pin mask decides whether a pending bit reaches an interrupt output.

The pins are organised in groups of eight. Each group has one control word, one mask word and one pending word on a small register bus. Pins 0 to 15 each drive their own interrupt line. Pins 16 to 31 are merged into one shared line, and a handler reads the pending words of the upper groups to find the source. All outputs and read data are registered.

Top module: `xint_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, every trigger code is 0, both interrupt outputs are 0 and read data is 0.
- R2: The register address is {group[1:0], kind[1:0]}, where kind 0 selects the control word, 1 the mask word, 2 the pending word and 3 reads as zero. Read data and bus_rvalid_o appear one clock after bus_rd_i.
- R3: In a control word, pin k of the group (k = pin mod 8) owns bits 4k+2..4k. Bit 4k+3 is not stored and reads 0.
- R4: Trigger code 3 sets the pending bit when the synchronised pin goes from 0 to 1.
- R5: Trigger code 2 sets the pending bit when the synchronised pin goes from 1 to 0.
- R6: Trigger code 4 sets the pending bit on either transition.
- R7: Code 0 (low level) and code 1 (high level) set the pending bit on every clock while the level holds. A pending bit cleared while its level is still active is set again in the same cycle.
- R8: Codes 5, 6 and 7 never set a pending bit, whatever the pin does.
- R9: Writing a 1 to a bit of a pending word clears that bit. Writing a 0 leaves it unchanged. A pending bit never falls unless a 1 was written to it.
- R10: A mask bit of 1 keeps the pin's output low, while its pending bit still latches. Clearing the mask bit of a pending pin raises the output on the next clock.
- R11: Output bit i of irq_ded_o (i = 0..15) is high exactly when, one clock earlier, pin i was pending and unmasked.
- R12: irq_shared_o is high when, one clock earlier, any pin from 16 to 31 was pending and unmasked.
- R13: Only bits 7..0 of the mask and pending words exist. Higher written bits are ignored and read back as 0.
- R14: A pin change first captured at clock edge N can set its pending bit at edge N+2 and reach its output at edge N+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous external interrupt pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address {group, kind} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | High one clock after a read strobe |
| irq_ded_o | output | 16 | Dedicated interrupt lines for pins 0 to 15 |
| irq_shared_o | output | 1 | Combined interrupt line for pins 16 to 31 |

## Verification
The assertions assume that no register write happens during reset. They also assume the pins rest high while reset is held, since the synchroniser resets to the idle-high value and a low pin at release would look like a falling edge. The stimulus holds all pins high through reset and starts register traffic only after release. It changes pins only on falling clock edges and leaves several cycles between pin changes, so each edge is seen as a single transition. Each bus access is a single-cycle strobe, and strobes are spaced apart, so reads and writes never overlap.

// File: rtl/xint_pkg.sv
package xint_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_t;

  localparam int TRIG_W = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_t;

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int W    = 32,
  parameter bit INIT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);

  localparam logic [W-1:0] RST_VAL = {W{INIT}};

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [W-1:0] prev_q;

  // two capture stages, then one more sample kept for edge comparison
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
      prev_q   <= RST_VAL;
    end else begin
      stage1_q <= pin_i;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign cur_o  = stage2_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
#(
  parameter int CODE_W = TRIG_W
) (
  input  logic              cur_i,
  input  logic              prev_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);

  logic rise;
  logic fall;

  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    unique case (code_i)
      CODE_W'(TRIG_LOW):  hit_o = ~cur_i;
      CODE_W'(TRIG_HIGH): hit_o = cur_i;
      CODE_W'(TRIG_FALL): hit_o = fall;
      CODE_W'(TRIG_RISE): hit_o = rise;
      CODE_W'(TRIG_BOTH): hit_o = rise | fall;
      default:            hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/xint_bank.sv
module xint_bank
  import xint_pkg::*;
#(
  parameter int GRP_PINS = 8,
  parameter int CODE_W   = TRIG_W,
  parameter int FIELD_W  = 4,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  reg_sel_t                   sel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [GRP_PINS-1:0]        hit_i,
  output logic [GRP_PINS*CODE_W-1:0] codes_o,
  output logic [GRP_PINS-1:0]        mask_o,
  output logic [GRP_PINS-1:0]        pend_o,
  output logic [DATA_W-1:0]          rdata_o
);

  localparam int CTRL_BITS = GRP_PINS * FIELD_W;
  localparam int PAD_W     = FIELD_W - CODE_W;
  localparam int TOP_W     = DATA_W - CTRL_BITS;
  localparam int FLAG_PAD  = DATA_W - GRP_PINS;

  logic [GRP_PINS-1:0][CODE_W-1:0] code_q;
  logic [GRP_PINS-1:0]             mask_q;
  logic [GRP_PINS-1:0]             pend_q;
  logic [GRP_PINS-1:0]             clr_vec;
  logic [GRP_PINS-1:0]             off_vec;
  logic [DATA_W-1:0]               ctrl_word;
  logic                            unused_wdata;

  // every write bit is looked at by some field or discarded on purpose
  assign unused_wdata = ^wdata_i;

  // trigger fields: fixed stride, only the code bits are stored
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (wr_en_i && sel_i == SEL_CTRL) begin
      for (int k = 0; k < GRP_PINS; k++) begin
        code_q[k] <= wdata_i[k*FIELD_W +: CODE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en_i && sel_i == SEL_MASK) begin
      mask_q <= wdata_i[GRP_PINS-1:0];
    end
  end

  // write-one-to-clear, with a new detection winning over a clear
  assign clr_vec = (wr_en_i && sel_i == SEL_PEND) ? wdata_i[GRP_PINS-1:0]
                                                  : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | hit_i;
    end
  end

  // read image of the control word
  for (genvar k = 0; k < GRP_PINS; k++) begin : g_field
    assign ctrl_word[k*FIELD_W +: CODE_W] = code_q[k];
    assign off_vec[k] = (code_q[k] > CODE_W'(TRIG_BOTH));
    if (PAD_W > 0) begin : g_pad
      assign ctrl_word[k*FIELD_W+CODE_W +: PAD_W] = '0;
    end
  end

  if (TOP_W > 0) begin : g_top
    assign ctrl_word[DATA_W-1:CTRL_BITS] = '0;
  end

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_o = ctrl_word;
      SEL_MASK: rdata_o = {{FLAG_PAD{1'b0}}, mask_q};
      SEL_PEND: rdata_o = {{FLAG_PAD{1'b0}}, pend_q};
      default:  rdata_o = '0;
    endcase
  end

  assign codes_o = code_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & $past(clr_vec & ~hit_i)) == '0));

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

  // R8
  disabled_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & $past(off_vec)) == '0));

endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter int GRP_PINS  = 8,
  parameter int CODE_W    = TRIG_W,
  parameter int FIELD_W   = 4,
  parameter int NUM_DED   = 16,
  parameter int DATA_W    = 32,
  parameter bit SYNC_INIT = 1'b1,
  parameter int ADDR_W    = $clog2(NUM_PINS / GRP_PINS) + SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                bus_rvalid_o,
  output logic [NUM_DED-1:0]  irq_ded_o,
  output logic                irq_shared_o
);

  localparam int NUM_GRPS = NUM_PINS / GRP_PINS;
  localparam int GRP_AW   = ADDR_W - SEL_W;
  localparam int NUM_SHR  = NUM_PINS - NUM_DED;

  logic [NUM_PINS-1:0]        pin_cur;
  logic [NUM_PINS-1:0]        pin_prev;
  logic [NUM_PINS-1:0]        hit_all;
  logic [NUM_PINS-1:0]        mask_all;
  logic [NUM_PINS-1:0]        pend_all;
  logic [NUM_PINS*CODE_W-1:0] code_all;
  logic [DATA_W-1:0]          rd_word [NUM_GRPS];
  logic [GRP_AW-1:0]          grp_sel;
  reg_sel_t                   kind_sel;
  logic [NUM_DED-1:0]         ded_q;
  logic                       shr_q;
  logic [DATA_W-1:0]          rdata_q;
  logic                       rvalid_q;

  assign grp_sel  = bus_addr_i[ADDR_W-1:SEL_W];
  assign kind_sel = reg_sel_t'(bus_addr_i[SEL_W-1:0]);

  xint_sync #(
    .W    (NUM_PINS),
    .INIT (SYNC_INIT)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    xint_detect #(
      .CODE_W (CODE_W)
    ) u_det (
      .cur_i  (pin_cur[p]),
      .prev_i (pin_prev[p]),
      .code_i (code_all[p*CODE_W +: CODE_W]),
      .hit_o  (hit_all[p])
    );
  end

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    logic grp_wr;
    assign grp_wr = bus_wr_i && (grp_sel == GRP_AW'(g));

    xint_bank #(
      .GRP_PINS (GRP_PINS),
      .CODE_W   (CODE_W),
      .FIELD_W  (FIELD_W),
      .DATA_W   (DATA_W)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en_i (grp_wr),
      .sel_i   (kind_sel),
      .wdata_i (bus_wdata_i),
      .hit_i   (hit_all[g*GRP_PINS +: GRP_PINS]),
      .codes_o (code_all[g*GRP_PINS*CODE_W +: GRP_PINS*CODE_W]),
      .mask_o  (mask_all[g*GRP_PINS +: GRP_PINS]),
      .pend_o  (pend_all[g*GRP_PINS +: GRP_PINS]),
      .rdata_o (rd_word[g])
    );
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) begin
        rdata_q <= rd_word[grp_sel];
      end
    end
  end

  // registered interrupt lines
  always_ff @(posedge clk) begin
    if (rst) begin
      ded_q <= '0;
      shr_q <= 1'b0;
    end else begin
      ded_q <= pend_all[NUM_DED-1:0] & ~mask_all[NUM_DED-1:0];
      shr_q <= |(pend_all[NUM_PINS-1:NUM_DED] & ~mask_all[NUM_PINS-1:NUM_DED]);
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign irq_ded_o    = ded_q;
  assign irq_shared_o = shr_q;

  // R10
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_ded_o & $past(mask_all[NUM_DED-1:0])) == '0));

  // R11
  ded_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_ded_o & ~$past(pend_all[NUM_DED-1:0])) == '0));

  // R12
  shared_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_shared_o) |-> ($past(pend_all[NUM_PINS-1:NUM_DED]) != {NUM_SHR{1'b0}}));

  // R2
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd_i |=> bus_rvalid_o);

endmodule

// File: tb/xint_ctrl_tb_top.sv
module xint_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pins;
  logic        bus_wr;
  logic        bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] irq_ded;
  logic        irq_shared;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  xint_ctrl dut_i (
    .clk          (clk),
    .rst          (rst),
    .pin_i        (pins),
    .bus_wr_i     (bus_wr),
    .bus_rd_i     (bus_rd),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .bus_rvalid_o (bus_rvalid),
    .irq_ded_o    (irq_ded),
    .irq_shared_o (irq_shared)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(int g, int k, logic [31:0] val);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = {2'(g), 2'(k)};
    bus_wdata = val;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  // driver side: queue the expected word, then issue the read
  task automatic rd_reg(int g, int k, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd   = 1'b1;
    bus_addr = {2'(g), 2'(k)};
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  // monitor side: every returned word is matched against the queue head
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    rst       = 1'b1;
    pins      = '1;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state
    check("R1 dedicated outputs", 32'(irq_ded), 32'h0);
    check("R1 shared output", 32'(irq_shared), 32'h0);
    check("R1 read data", bus_rdata, 32'h0);
    for (int g = 0; g < 4; g++) begin
      rd_reg(g, 0, 32'h0, "R1 control word");
      rd_reg(g, 1, 32'hFF, "R1 mask word");
      rd_reg(g, 2, 32'h0, "R1 pending word");
    end
    // R2 kind 3 reads zero
    rd_reg(0, 3, 32'h0, "R2 unused kind");
    rd_reg(2, 3, 32'h0, "R2 unused kind group2");

    // R3 field layout, reserved bit 4k+3 dropped
    wr_reg(0, 0, 32'hFFFF_FFFF);
    rd_reg(0, 0, 32'h7777_7777, "R3 reserved bits");
    // pin0 rise, pin1 fall, pin2 both, pin3 low, pin4 high, pins5-7 codes 5,6,7
    wr_reg(0, 0, 32'h7651_0423);
    rd_reg(0, 0, 32'h7651_0423, "R3 field readback");
    wait_clk(6);
    // pins all high: only high-level pin4 pends
    rd_reg(0, 2, 32'h10, "R7 high level");

    // all pins low
    pins = '0;
    wait_clk(6);
    rd_reg(0, 2, 32'h1E, "R5 R6 R7 falling, both, low");
    wr_reg(0, 2, 32'hFF);
    wait_clk(2);
    rd_reg(0, 2, 32'h08, "R9 R7 clear with low level active");
    rd_reg(1, 2, 32'hFF, "R7 R13 group1 low level");

    // all pins high
    pins = '1;
    wait_clk(6);
    rd_reg(0, 2, 32'h1D, "R4 R6 R8 rising, both, disabled codes");
    wr_reg(0, 2, 32'hFF);
    wait_clk(2);
    rd_reg(0, 2, 32'h10, "R9 R7 clear with high level active");

    // all pins low again, masking behaviour
    pins = '0;
    wait_clk(6);
    rd_reg(0, 2, 32'h1E, "R8 R5 second fall");
    wr_reg(0, 2, 32'hFF);
    wait_clk(4);
    check("R10 masked pending stays quiet", 32'(irq_ded), 32'h0);
    wr_reg(0, 1, 32'hF7);
    wait_clk(2);
    check("R10 R11 unmask raises pin3", 32'(irq_ded), 32'h0008);
    wr_reg(0, 2, 32'h00);
    wait_clk(2);
    rd_reg(0, 2, 32'h08, "R9 write zero no effect");

    // R14 latency of a rising edge on pin0
    wr_reg(0, 1, 32'hF6);
    wait_clk(2);
    pins[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R14 not yet at edge N+2", 32'(irq_ded), 32'h0008);
    @(posedge clk);
    @(negedge clk);
    check("R14 R4 output at edge N+3", 32'(irq_ded), 32'h0009);
    wr_reg(0, 2, 32'h01);
    wait_clk(3);
    rd_reg(0, 2, 32'h08, "R9 clear edge pending");
    check("R9 R11 output after clear", 32'(irq_ded), 32'h0008);

    // R13 upper mask bits ignored, R11 group1 lines
    wr_reg(1, 1, 32'hABCD_EF00);
    wait_clk(3);
    rd_reg(1, 1, 32'h0, "R13 mask upper bits");
    check("R11 group1 dedicated lines", 32'(irq_ded), 32'hFF08);

    // R12 shared line
    check("R12 shared masked", 32'(irq_shared), 32'h0);
    wr_reg(3, 1, 32'hDF);
    wait_clk(3);
    check("R12 shared from pin29", 32'(irq_shared), 32'h1);
    wr_reg(3, 0, 32'h7777_7777);
    wr_reg(3, 2, 32'hFF);
    wait_clk(3);
    check("R12 R8 shared low after clear", 32'(irq_shared), 32'h0);
    rd_reg(3, 2, 32'h0, "R8 disabled group3 stays clear");
    wr_reg(2, 1, 32'hFE);
    wait_clk(3);
    check("R12 shared from pin16", 32'(irq_shared), 32'h1);

    wait_clk(4);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 missing read data actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    report();
    $finish;
  end

endmodule